// File: doc/BRIEF.md
# Audio Clock Chain Sequencer

This block controls three chained clock dividers for a serial ADC/DAC audio link: a master-clock divider fed from a fixed reference, a bit-clock divider that divides the master clock by a fixed ratio, and a frame-clock divider that divides the bit clock by a fixed ratio. A configuration request carries a desired sample rate. The block clamps that rate to a legal window and derives the master division from the reference. It then reports the sample rate that this integer division actually achieves. One shared iterative divider performs both computations.

Start and stop are ordered sequences that advance one step per clock. The stop sequence places each divider in reset, in chain order, and then releases them in the same order, which leaves all three disabled. The start sequence enables the master divider and then the bit divider. Next it runs the frame divider for a while on a temporary, longer count, and finally loads the real frame count. This places the frame-clock edges at a known offset from the bit clock. An active-low enable for the external clock drivers goes low once the first configuration has finished.

Top module: `audio_clk_seq`

## Requirements
- R1: After reset, every enable and reset output is 0, busy is 0, rate_done is 0, drv_en_n is 1 and m_cnt is 0.
- R2: A requested rate below MIN_RATE is treated as MIN_RATE, and one above MAX_RATE (the 64x oversampling limit) is treated as MAX_RATE.
- R3: When a configuration completes, m_cnt equals floor(REF_HZ / (clamped rate * M2B * B2F)) - 1. All count outputs are minus-one encoded.
- R4: rate_act equals floor(REF_HZ / (master division * M2B * B2F)). rate_done is a one-cycle pulse that is high in the cycle 2*DW clocks after the edge that accepted cfg_req.
- R5: b_cnt always equals M2B-1, and the settled frame count f_cnt equals B2F-1.
- R6: Start takes effect on the edges that follow the accepting edge, in this order: m_en, then b_en, then f_en together with the temporary frame count, then the real frame count.
- R7: The temporary frame count is ((M2B/4)-2)*10+6 + M2B/2 - 1, which is 33 at the defaults.
- R8: Stop sets m_rst, b_rst and f_rst on successive edges and clears the matching enable each time. It then clears the three resets in the same order, leaving all enables at 0.
- R9: busy is high from the edge after the accepting edge until the final step. start_req and stop_req are ignored while busy is high.
- R10: If start_req and stop_req arrive together while idle, the stop sequence runs.
- R11: drv_en_n goes low with the first rate_done and stays low afterwards.
- R12: A cfg_req that arrives while a computation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req | input | 1 | Latch rate_req and begin computing |
| rate_req | input | RW | Requested sample rate in Hz |
| start_req | input | 1 | Begin the start sequence |
| stop_req | input | 1 | Begin the stop sequence |
| busy | output | 1 | A start or stop sequence is running |
| m_en | output | 1 | Master divider enable |
| m_rst | output | 1 | Master divider reset |
| b_en | output | 1 | Bit divider enable |
| b_rst | output | 1 | Bit divider reset |
| f_en | output | 1 | Frame divider enable |
| f_rst | output | 1 | Frame divider reset |
| m_cnt | output | CW | Master count, minus-one encoded |
| b_cnt | output | CW | Bit count, minus-one encoded |
| f_cnt | output | CW | Frame count, minus-one encoded |
| rate_act | output | RW | Achieved sample rate |
| rate_done | output | 1 | rate_act and m_cnt are valid |
| drv_en_n | output | 1 | Active-low enable for the clock drivers |

## Verification
Two pairs of functions can fall in the same cycle. The first is a start request and a stop request asserted together while idle; the bench raises both at the same edge and expects the exact stop-order reset pattern on the following edges. The second is a sequence request that arrives while a sequence is running, or a configuration request that arrives while the divider is busy; the bench injects each mid-run and judges by the ports afterwards: no reset output appears, the enables stay as the first sequence left them, and the scoreboard receives only the first configuration's result, with no extra rate_done.

// File: rtl/audio_clk_seq.sv
module audio_clk_seq #(
  parameter int REF_HZ   = 98_304_000,
  parameter int MIN_RATE = 8000,
  parameter int MAX_RATE = 96000,
  parameter int M2B      = 16,
  parameter int B2F      = 64,
  parameter int DW       = 32,
  parameter int RW       = 20,
  parameter int CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_req,
  input  logic [RW-1:0] rate_req,
  input  logic          start_req,
  input  logic          stop_req,
  output logic          busy,
  output logic          m_en,
  output logic          m_rst,
  output logic          b_en,
  output logic          b_rst,
  output logic          f_en,
  output logic          f_rst,
  output logic [CW-1:0] m_cnt,
  output logic [CW-1:0] b_cnt,
  output logic [CW-1:0] f_cnt,
  output logic [RW-1:0] rate_act,
  output logic          rate_done,
  output logic          drv_en_n
);
  localparam int K   = M2B * B2F;
  localparam int DLY = ((M2B / 4) - 2) * 10 + 6;
  localparam int TMP = DLY + M2B / 2 - 1;
  localparam int NW  = $clog2(DW + 1);

  logic [DW-1:0] num, den, rem, quo, rate_c;
  logic [NW-1:0] cnt;
  logic [1:0]    stage;
  logic [2:0]    step;
  logic          stopping;

  wire [DW-1:0] rsh = {rem[DW-2:0], num[DW-1]};
  wire          ge  = rsh >= den;
  wire [DW-1:0] rnx = ge ? rsh - den : rsh;
  wire [DW-1:0] qnx = {quo[DW-2:0], ge};

  always_comb begin
    rate_c = DW'(rate_req);
    if (rate_c < DW'(MIN_RATE)) rate_c = DW'(MIN_RATE);
    else if (rate_c > DW'(MAX_RATE)) rate_c = DW'(MAX_RATE);
  end

  assign b_cnt = CW'(M2B - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num <= '0; den <= '1; rem <= '0; quo <= '0; cnt <= '0; stage <= 2'd0;
      m_cnt <= '0; rate_act <= '0; rate_done <= 1'b0; drv_en_n <= 1'b1;
    end else begin
      rate_done <= 1'b0;
      if (stage == 2'd0) begin
        if (cfg_req) begin
          num <= DW'(REF_HZ); den <= rate_c * DW'(K);
          rem <= '0; quo <= '0; cnt <= NW'(DW); stage <= 2'd1;
        end
      end else begin
        num <= num << 1; rem <= rnx; quo <= qnx; cnt <= cnt - 1'b1;
        if (cnt == NW'(1)) begin
          num <= DW'(REF_HZ); rem <= '0; quo <= '0; cnt <= NW'(DW);
          if (stage == 2'd1) begin
            m_cnt <= CW'(qnx - 1'b1);
            den   <= qnx * DW'(K);
            stage <= 2'd2;
          end else begin
            rate_act  <= RW'(qnx);
            rate_done <= 1'b1;
            drv_en_n  <= 1'b0;
            stage     <= 2'd0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; stopping <= 1'b0; step <= '0;
      m_en <= 1'b0; b_en <= 1'b0; f_en <= 1'b0;
      m_rst <= 1'b0; b_rst <= 1'b0; f_rst <= 1'b0;
      f_cnt <= CW'(B2F - 1);
    end else if (!busy) begin
      if (stop_req || start_req) begin
        busy <= 1'b1; stopping <= stop_req; step <= '0;
      end
    end else begin
      step <= step + 1'b1;
      if (stopping) begin
        case (step)
          3'd0: begin m_rst <= 1'b1; m_en <= 1'b0; end
          3'd1: begin b_rst <= 1'b1; b_en <= 1'b0; end
          3'd2: begin f_rst <= 1'b1; f_en <= 1'b0; end
          3'd3: m_rst <= 1'b0;
          3'd4: b_rst <= 1'b0;
          default: begin f_rst <= 1'b0; busy <= 1'b0; end
        endcase
      end else begin
        case (step)
          3'd0: m_en <= 1'b1;
          3'd1: b_en <= 1'b1;
          3'd2: begin f_en <= 1'b1; f_cnt <= CW'(TMP); end
          default: begin f_cnt <= CW'(B2F - 1); busy <= 1'b0; end
        endcase
      end
    end
  end
endmodule

module audio_clk_seq_chk #(
  parameter int M2B = 16,
  parameter int B2F = 64,
  parameter int CW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_en,
  input logic          m_rst,
  input logic          b_en,
  input logic          b_rst,
  input logic          f_en,
  input logic          f_rst,
  input logic [CW-1:0] f_cnt,
  input logic          rate_done,
  input logic          drv_en_n,
  input logic          busy
);
  localparam int TMPC = ((M2B / 4) - 2) * 10 + 6 + M2B / 2 - 1;

  p_bit_after_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_en) |-> m_en);
  p_frame_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_en) |-> b_en);
  p_temp_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_en) |-> f_cnt == CW'(TMPC));
  p_real_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_en) |=> f_cnt == CW'(B2F - 1));
  p_stop_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_rst) |-> m_rst && !m_en);
  p_stop_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_rst) |-> b_rst && !b_en);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_done |=> !rate_done);
  p_drv_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_n |=> !drv_en_n);
  p_rst_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_rst) |-> busy);
endmodule

bind audio_clk_seq audio_clk_seq_chk #(.M2B(M2B), .B2F(B2F), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_en(m_en), .m_rst(m_rst), .b_en(b_en),
  .b_rst(b_rst), .f_en(f_en), .f_rst(f_rst), .f_cnt(f_cnt),
  .rate_done(rate_done), .drv_en_n(drv_en_n), .busy(busy)
);

// File: tb/audio_clk_seq_tb.sv
`timescale 1ns/1ps
module audio_clk_seq_tb;
  localparam longint REF = 98_304_000;
  localparam longint KR  = 16 * 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_req = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic [19:0] rate_req = '0;
  logic busy, m_en, m_rst, b_en, b_rst, f_en, f_rst, rate_done, drv_en_n;
  logic [15:0] m_cnt, b_cnt, f_cnt;
  logic [19:0] rate_act;

  int total = 0, bad = 0;
  longint exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  audio_clk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .rate_req(rate_req),
    .start_req(start_req), .stop_req(stop_req), .busy(busy),
    .m_en(m_en), .m_rst(m_rst), .b_en(b_en), .b_rst(b_rst),
    .f_en(f_en), .f_rst(f_rst), .m_cnt(m_cnt), .b_cnt(b_cnt),
    .f_cnt(f_cnt), .rate_act(rate_act), .rate_done(rate_done),
    .drv_en_n(drv_en_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_cfg(input longint r, input bit expect_result);
    longint rc, md;
    rc = r < 8000 ? 8000 : (r > 96000 ? 96000 : r);
    md = REF / (rc * KR);
    if (expect_result) begin
      exp_q.push_back(md - 1);
      exp_q.push_back(REF / (md * KR));
    end
    rate_req = 20'(r);
    cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
  endtask

  // monitor: pop and compare on each rate_done
  always @(negedge clk) begin
    if (rst_n && rate_done) begin
      if (exp_q.size() < 2) chk(0, "R12 unexpected rate_done", 1, 0);
      else begin
        longint em, er;
        em = exp_q.pop_front();
        er = exp_q.pop_front();
        chk(m_cnt == em, "R3 m_cnt", m_cnt, em);
        chk(rate_act == er, "R4 rate_act", rate_act, er);
        chk(drv_en_n == 1'b0, "R11 drv_en_n", drv_en_n, 0);
      end
    end
  end

  task automatic run_cfg(input longint r);
    push_cfg(r, 1);
    repeat (63) @(negedge clk);
    chk(rate_done == 1'b0, "R4 early done", rate_done, 0);
    @(negedge clk);
    chk(rate_done == 1'b1, "R4 done latency", rate_done, 1);
    @(negedge clk);
    chk(rate_done == 1'b0, "R4 pulse width", rate_done, 0);
  endtask

  task automatic do_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(busy == 1'b1 && m_en == 1'b0, "R9 busy after accept", busy, 1);
    @(negedge clk);
    chk(m_en && !b_en, "R6 master first", {m_en, b_en}, 2);
    @(negedge clk);
    chk(b_en && !f_en, "R6 bit second", {b_en, f_en}, 2);
    @(negedge clk);
    chk(f_en && f_cnt == 33, "R7 temp frame count", f_cnt, 33);
    chk(busy == 1'b1, "R9 busy mid", busy, 1);
    @(negedge clk);
    chk(f_cnt == 63, "R5 real frame count", f_cnt, 63);
    chk(busy == 1'b0, "R9 busy end", busy, 0);
  endtask

  task automatic expect_stop();
    @(negedge clk);
    chk(busy && !m_rst, "R9 busy after stop accept", busy, 1);
    @(negedge clk);
    chk(m_rst && !m_en && !b_rst, "R8 master reset first", {m_rst, m_en, b_rst}, 4);
    @(negedge clk);
    chk(b_rst && !b_en && !f_rst, "R8 bit reset second", {b_rst, b_en, f_rst}, 4);
    @(negedge clk);
    chk(f_rst && !f_en, "R8 frame reset third", {f_rst, f_en}, 2);
    @(negedge clk);
    chk(!m_rst && b_rst && f_rst, "R8 master release", {m_rst, b_rst, f_rst}, 3);
    @(negedge clk);
    chk(!b_rst && f_rst, "R8 bit release", {b_rst, f_rst}, 1);
    @(negedge clk);
    chk(!f_rst && !busy && !m_en && !b_en && !f_en, "R8 final all disabled",
        {f_rst, busy, m_en, b_en, f_en}, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({m_en, b_en, f_en, m_rst, b_rst, f_rst, busy, rate_done} == 0, "R1 outputs idle",
        {m_en, b_en, f_en, m_rst, b_rst, f_rst, busy, rate_done}, 0);
    chk(drv_en_n == 1'b1 && m_cnt == 0, "R1 drv_en_n and m_cnt", drv_en_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(b_cnt == 15, "R5 bit count", b_cnt, 15);

    run_cfg(48000);
    run_cfg(44100);
    run_cfg(30000);
    run_cfg(1000);    // R2 low clamp
    run_cfg(200000);  // R2 high clamp
    run_cfg(8000);

    // R12: second cfg while computing is ignored
    push_cfg(48000, 1);
    repeat (10) @(negedge clk);
    push_cfg(8000, 0);
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);

    do_start();

    // R9: requests ignored while busy
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(busy && !m_rst, "R9 stop during busy", m_rst, 0);
    repeat (6) @(negedge clk);
    chk(!busy && m_en && b_en && f_en && !m_rst && !b_rst && !f_rst,
        "R9 stop request ignored", {busy, m_rst, b_rst, f_rst}, 0);
    chk(f_cnt == 63, "R5 frame count kept", f_cnt, 63);

    // R10: both together while idle, stop wins
    start_req = 1'b1; stop_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0;
    chk(busy == 1'b1, "R10 accepted", busy, 1);
    @(negedge clk);
    chk(m_rst && !m_en, "R10 stop wins", {m_rst, m_en}, 2);
    repeat (5) @(negedge clk);
    chk(!busy && !m_en && !b_en && !f_en, "R10 ends stopped", {m_en, b_en, f_en}, 0);

    // plain stop after a restart
    do_start();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    begin
      // first check at the negedge already reached
      chk(busy == 1'b1, "R9 busy on stop", busy, 1);
    end
    repeat (1) begin end
    // remaining steps (expect_stop begins one negedge later; align)
    chk(m_rst == 1'b0, "R8 no reset before first step", m_rst, 0);
    @(negedge clk);
    chk(m_rst && !m_en, "R8 master reset", {m_rst, m_en}, 2);
    @(negedge clk);
    chk(b_rst && !b_en, "R8 bit reset", {b_rst, b_en}, 2);
    @(negedge clk);
    chk(f_rst && !f_en, "R8 frame reset", {f_rst, f_en}, 2);
    repeat (3) @(negedge clk);
    chk(!m_rst && !b_rst && !f_rst && !busy, "R8 all released", {m_rst, b_rst, f_rst}, 0);

    do_start();
    stop_req = 1'b1;
    expect_stop_wrap();
    chk(drv_en_n == 1'b0, "R11 drv_en_n held", drv_en_n, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic expect_stop_wrap();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(busy == 1'b1, "R9 busy high", busy, 1);
    @(negedge clk);
    chk(m_rst && !b_rst, "R8 order m", {m_rst, b_rst}, 2);
    @(negedge clk);
    chk(b_rst && !f_rst, "R8 order b", {b_rst, f_rst}, 2);
    @(negedge clk);
    chk(f_rst, "R8 order f", f_rst, 1);
    @(negedge clk);
    chk(!m_rst && b_rst, "R8 release m", {m_rst, b_rst}, 1);
    @(negedge clk);
    chk(!b_rst && f_rst, "R8 release b", {b_rst, f_rst}, 1);
    @(negedge clk);
    chk(!f_rst && !busy && !m_en && !b_en && !f_en, "R8 release f", {f_rst, busy}, 0);
  endtask
endmodule